// File: doc/BRIEF.md
# Sequential Unsigned Divider

This block divides one unsigned `WIDTH`-bit operand by another, one quotient bit per clock. A single-cycle `start` with the operands loads three working registers. The partial remainder is one bit wider than the operands, so its top bit acts as a sign. The dividend register shifts left and collects quotient bits, and the divisor register holds the divisor for the whole run. After `WIDTH` iterations, one extra cycle corrects the remainder and publishes both results with a one-cycle `done` pulse.

The parameter `RESTORING` selects the arithmetic core. With `RESTORING = 0`, each iteration does exactly one add or subtract. The sign of the partial remainder decides which one, and a negative final remainder gets the divisor added back once. With `RESTORING = 1`, each iteration does a trial subtraction and keeps the old value when the result goes negative, so no final correction is needed. Both cores give the same results and the same latency.

All pins are plain control, status and data. `start` is a request that is only honoured while idle, and nothing at the edge can be stalled, so there is no back-pressure. The results stay on the outputs until the next accepted `start`.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are all zeros.
- R2: `start` is accepted only when `busy` is 0, and `busy` is 1 in the cycle after acceptance. A `start` while `busy` is 1 is ignored and does not change the operands of the running division.
- R3: `done` is 1 for exactly one cycle. It rises on the `WIDTH+1`-th rising edge after the edge that accepted `start`, and `busy` is 0 whenever `done` is 1.
- R4: With `RESTORING = 0` and a non-zero divisor, `quotient` equals the integer floor of dividend/divisor and `remainder` equals dividend mod divisor. For example, 0111 / 0011 gives quotient 0010 and remainder 0001.
- R5: With `RESTORING = 1`, the block gives the same quotient and remainder as in R4 for every operand pair with a non-zero divisor.
- R6: Whenever `done` is 1 and the divisor is non-zero, `remainder` is strictly less than the divisor. A negative partial remainder never reaches the output.
- R7: `div_zero` is 1 together with `done` when the divisor was zero, and 0 otherwise. In that case `quotient` and `remainder` carry no defined value.
- R8: `quotient`, `remainder` and `div_zero` keep their values from the `done` cycle until the next accepted `start` completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division with the operands present in this cycle |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| div_zero | output | 1 | The divisor of the finished division was zero |
| quotient | output | WIDTH | Unsigned quotient |
| remainder | output | WIDTH | Unsigned remainder |

## Verification
Several faults show up at the result outputs in the cycle `done` rises, `WIDTH+1` edges after acceptance:
- A wrong add/subtract choice, a lost sign bit in the partial remainder, or a missing final correction gives a quotient or remainder that differs from integer division.
- The missing correction often also gives a remainder at or above the divisor.

An iteration counter that is off by one moves the `done` pulse by a cycle and scales the quotient by two. Operand capture that listens to `start` during a run shows up as the result of the wrong operands.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl #(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic fix_en,
  output logic busy
);
  import div_pkg::*;
  localparam int CW = $clog2(WIDTH + 1);

  div_state_e       state;
  logic [CW-1:0]    left;

  assign load    = (state == ST_IDLE) && start;
  assign step_en = (state == ST_RUN);
  assign fix_en  = (state == ST_FIX);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      left  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          left  <= CW'(WIDTH);
        end
        ST_RUN: begin
          left <= left - 1'b1;
          if (left == CW'(1)) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH     = 4,
  parameter bit RESTORING = 1'b0
) (
  input  logic [WIDTH:0]   a_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic [WIDTH-1:0] m,
  output logic [WIDTH:0]   a_out,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH:0]   a_sh;
  logic [WIDTH-1:0] q_sh;
  logic [WIDTH:0]   m_ext;

  assign {a_sh, q_sh} = {a_in[WIDTH-1:0], q_in, 1'b0};
  assign m_ext        = {1'b0, m};

  generate
    if (RESTORING) begin : g_restore
      logic [WIDTH:0] trial;
      assign trial = a_sh - m_ext;
      always_comb begin
        if (trial[WIDTH]) begin
          a_out = a_sh;
          q_out = q_sh;
        end else begin
          a_out = trial;
          q_out = q_sh | WIDTH'(1);
        end
      end
    end else begin : g_nonrestore
      always_comb begin
        if (a_in[WIDTH]) a_out = a_sh + m_ext;
        else             a_out = a_sh - m_ext;
        q_out = q_sh | WIDTH'(!a_out[WIDTH]);
      end
    end
  endgenerate
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int WIDTH     = 4,
  parameter bit RESTORING = 1'b0
) (
  input  logic [WIDTH:0]   a_in,
  input  logic [WIDTH-1:0] m,
  output logic [WIDTH-1:0] rem
);
  generate
    if (RESTORING) begin : g_pass
      assign rem = a_in[WIDTH-1:0];
    end else begin : g_correct
      logic [WIDTH:0] sum;
      assign sum = a_in + {1'b0, m};
      assign rem = a_in[WIDTH] ? sum[WIDTH-1:0] : a_in[WIDTH-1:0];
    end
  endgenerate
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH     = 4,
  parameter bit RESTORING = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic             load, step_en, fix_en;
  logic [WIDTH:0]   a_q, a_nx;
  logic [WIDTH-1:0] q_q, q_nx, m_q, rem_fix;
  logic             zero_q;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step_en(step_en), .fix_en(fix_en), .busy(busy)
  );

  div_step #(.WIDTH(WIDTH), .RESTORING(RESTORING)) u_step (
    .a_in(a_q), .q_in(q_q), .m(m_q), .a_out(a_nx), .q_out(q_nx)
  );

  div_fix #(.WIDTH(WIDTH), .RESTORING(RESTORING)) u_fix (
    .a_in(a_q), .m(m_q), .rem(rem_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      q_q    <= '0;
      m_q    <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      a_q    <= '0;
      q_q    <= dividend;
      m_q    <= divisor;
      zero_q <= (divisor == '0);
    end else if (step_en) begin
      a_q <= a_nx;
      q_q <= q_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= fix_en;
      if (fix_en) begin
        quotient  <= q_q;
        remainder <= rem_fix;
        div_zero  <= zero_q;
      end
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             div_zero,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic [WIDTH-1:0] m_q
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (busy)  run_len <= run_len + 16'd1;
    else            run_len <= '0;
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                   // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                              // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                              // R3
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == 16'(WIDTH + 1)));                        // R3
  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < m_q));                   // R6
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_zero == (m_q == '0)));                          // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_zero))); // R8
endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .div_zero(div_zero), .quotient(quotient), .remainder(remainder), .m_q(m_q)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy0, done0, dz0, busy1, done1, dz1;
  logic [W-1:0] quo0, rem0, quo1, rem1;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  seq_divider #(.WIDTH(W), .RESTORING(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy0), .done(done0), .div_zero(dz0), .quotient(quo0), .remainder(rem0)
  );
  seq_divider #(.WIDTH(W), .RESTORING(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy1), .done(done1), .div_zero(dz1), .quotient(quo1), .remainder(rem1)
  );

  function automatic logic [W-1:0] exp_quo(input logic [W-1:0] a, input logic [W-1:0] b);
    return W'(int'(a) / int'(b));
  endfunction
  function automatic logic [W-1:0] exp_rem(input logic [W-1:0] a, input logic [W-1:0] b);
    return W'(int'(a) % int'(b));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!done0 && cycles < 50);
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b);
    int cyc;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start nonrestoring", busy0, 1);
    check("R2 busy after start restoring", busy1, 1);
    wait_done(cyc);
    check("R3 latency", cyc, W + 1);
    check("R3 done together", done1, 1);
    check("R3 not busy at done", busy0, 0);
    if (b != 0) begin
      check("R4 quotient", quo0, exp_quo(a, b));
      check("R4 remainder", rem0, exp_rem(a, b));
      check("R5 quotient restoring", quo1, exp_quo(a, b));
      check("R5 remainder restoring", rem1, exp_rem(a, b));
      check("R6 remainder below divisor", rem0 < b, 1);
      check("R7 no zero flag", {dz1, dz0}, 0);
    end else begin
      check("R7 zero flag", {dz1, dz0}, 2'b11);
    end
    @(negedge clk);
    check("R3 done single cycle", done0, 0);
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy0, 0);
    check("R1 done reset", done0, 0);
    check("R1 zero flag reset", dz0, 0);
    check("R1 quotient reset", quo0, 0);
    check("R1 remainder reset", rem0, 0);
    rst_n = 1'b1;

    run_div(4'b0111, 4'b0011);
    check("R4 directed quotient 0010", quo0, 4'b0010);
    check("R4 directed remainder 0001", rem0, 4'b0001);
    run_div(4'hF, 4'h1);
    run_div(4'h0, 4'hF);
    run_div(4'hF, 4'hF);
    run_div(4'h9, 4'h0);

    for (int a = 0; a < 16; a++)
      for (int b = 1; b < 16; b++)
        run_div(W'(a), W'(b));

    for (int i = 0; i < 200; i++)
      run_div(W'($urandom), W'($urandom));

    // R2: a start during a run must be ignored
    @(negedge clk);
    start = 1'b1; dividend = 4'd9; divisor = 4'd2;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; dividend = 4'd15; divisor = 4'd1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check("R2 ignored start quotient", quo0, 4'd4);
    check("R2 ignored start remainder", rem0, 4'd1);
    check("R2 ignored start restoring", {quo1, rem1}, {4'd4, 4'd1});

    // R8: results hold while idle even as inputs change
    dividend = 4'd3; divisor = 4'd0;
    repeat (4) @(negedge clk);
    check("R8 quotient held", quo0, 4'd4);
    check("R8 remainder held", rem0, 4'd1);
    check("R8 flag held", dz0, 0);
    check("R8 still idle", busy0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule